// File: doc/BRIEF.md
# Type-C Configuration-Channel Attach and Orientation Detector

This block sits between the comparators on the two configuration-channel pins of a reversible connector and the rest of the port logic. Each clock it receives a two-bit level code per pin and decides whether a partner is connected, which pin carries the connection, and what power role the port takes. The analog side, the termination resistors, the power-delivery messaging and the supply switch all live outside it.

The port can be strapped as a fixed source, a fixed sink, or a dual-role port. In dual-role mode the block alternates between asking for a pull-up and a pull-down on a programmable period and split. The first debounced attach locks the role. As a sink it reports the current class that the partner advertises. As a source it steers the cable-marker supply onto the pin opposite the connection when an active-cable load appears there. Detach uses its own, shorter debounce. Once detached the block goes back to searching.

The level code means different things depending on the termination the port presents. With pull-up (source): 0 = open, 1 = active-cable load, 2 = sink pull-down, 3 = invalid (treated as open). With pull-down (sink): 0 = open, 1 = default USB current, 2 = 1.5 A, 3 = 3 A.

Top module: `cc_attach_det`

## Requirements
- R1: After reset, `attached`, `orient`, `power_role`, `vconn_cc1`, `vconn_cc2` are 0 and `cur_class` is 0. In dual-role mode `pull_up` starts at 1.
- R2: An attach is declared only after the pin levels and `pull_up` have held one valid candidate unchanged for ATT_DBC clock edges after the edge that first captured it. `attached` rises on edge ATT_DBC+1, counting the first. Any change to those levels restarts the count.
- R3: An attached port detaches only after the attached pin has shown no partner on DET_DBC consecutive edges. A shorter loss leaves it attached.
- R4: `orient` is 0 when the partner is on CC1 and 1 when it is on CC2. `lane_flip` equals `orient`. Both stay stable while attached.
- R5: While presenting pull-up, code 2 on exactly one pin attaches as source (`power_role` = 1).
- R6: While presenting pull-down, a nonzero code on exactly one pin attaches as sink (`power_role` = 0). `cur_class` reports 1 = default, 2 = 1.5 A, 3 = 3 A, and follows a nonzero code change on that pin one edge later. It is 0 whenever the port is not an attached sink, so the reported capability never exceeds 3 A.
- R7: `role_cfg` encodes 0 = sink, 1 = source, 2 or 3 = dual-role. In dual-role mode `pull_up` repeats a cycle of TOG_PERIOD clocks, the first TOG_SRC of them high. Toggling freezes while a candidate is seen and stops while attached, and the role at attach is kept.
- R8: Open on both pins, a partner level on both pins at once, an active-cable load alone, or code 3 under pull-up all leave the port unattached.
- R9: An attached source with code 1 on the pin opposite the partner drives VCONN onto that opposite pin only. VCONN is otherwise off and is never driven onto the connected pin.
- R10: On detach, VCONN turns off on the same edge that `attached` falls. A dual-role port then resumes toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_cfg | input | 2 | 0 sink, 1 source, 2/3 dual-role |
| cc1_lvl | input | 2 | Comparator level code of pin CC1 |
| cc2_lvl | input | 2 | Comparator level code of pin CC2 |
| attached | output | 1 | Partner attached |
| orient | output | 1 | 0 = CC1 connected, 1 = CC2 connected |
| lane_flip | output | 1 | Data-lane swap select |
| power_role | output | 1 | 1 = source, 0 = sink (valid when attached) |
| cur_class | output | 2 | Advertised current class seen as sink |
| vconn_cc1 | output | 1 | Cable-marker supply onto CC1 |
| vconn_cc2 | output | 1 | Cable-marker supply onto CC2 |
| pull_up | output | 1 | 1 = present pull-up, 0 = present pull-down |

## Verification
The following properties are checked on every cycle:
- an attach never follows fewer than ATT_DBC stable samples;
- termination and orientation hold still while attached;
- VCONN appears only on an attached source, never on the connected pin, and never while unattached;
- a current class shows only for an attached sink.

Other behaviour can only be shown by the bench's scenarios:
- exact attach and detach edge counts;
- the restart of the count after a glitch;
- the class decode per code;
- the rejection of both-pin and open patterns;
- the toggle duty;
- the role taken from a modelled partner in dual-role mode, and the return to toggling after detach.

// File: rtl/cc_det_pkg.sv
package cc_det_pkg;

    typedef enum logic [1:0] {
        CFG_SINK = 2'd0,
        CFG_SRC  = 2'd1,
        CFG_DRP  = 2'd2,
        CFG_DRP2 = 2'd3
    } role_cfg_e;

    typedef enum logic {
        ST_UNATT = 1'b0,
        ST_ATT   = 1'b1
    } att_state_e;

    // codes seen while presenting pull-up
    localparam logic [1:0] LVL_OPEN = 2'd0;
    localparam logic [1:0] LVL_RA   = 2'd1;
    localparam logic [1:0] LVL_RD   = 2'd2;

    typedef struct packed {
        logic       valid;
        logic       pin;       // 0 = CC1, 1 = CC2
        logic [1:0] cls;       // advertised class when sink
        logic       ra_other;  // cable load on the opposite pin
    } cand_t;

    typedef struct packed {
        logic       pu;
        logic [1:0] c1;
        logic [1:0] c2;
    } obs_t;

    function automatic logic partner_seen(logic pu, logic [1:0] code);
        return pu ? (code == LVL_RD) : (code != LVL_OPEN);
    endfunction

    function automatic cand_t classify(logic pu, logic [1:0] c1, logic [1:0] c2);
        cand_t r;
        logic  s1, s2;
        s1 = partner_seen(pu, c1);
        s2 = partner_seen(pu, c2);
        r.valid    = s1 ^ s2;
        r.pin      = s2;
        r.cls      = pu ? 2'd0 : (s2 ? c2 : c1);
        r.ra_other = pu && (s2 ? (c1 == LVL_RA) : (c2 == LVL_RA));
        if (!r.valid) r = '0;
        return r;
    endfunction

endpackage

// File: rtl/cc_drp_toggle.sv
module cc_drp_toggle #(
    parameter int unsigned PERIOD  = 64,
    parameter int unsigned SRC_CYC = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic pu
);
    localparam int unsigned TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [TW-1:0] tcnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            tcnt_q <= '0;
        else if (run)
            tcnt_q <= (tcnt_q == TW'(PERIOD - 1)) ? '0 : tcnt_q + 1'b1;
    end

    assign pu = (32'(tcnt_q) < SRC_CYC);
endmodule

// File: rtl/cc_hold_timer.sv
module cc_hold_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    output logic done
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign done = cond && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cond && !done)
            cnt_q <= cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end
endmodule

// File: rtl/cc_attach_det.sv
module cc_attach_det
    import cc_det_pkg::*;
#(
    parameter int unsigned ATT_DBC    = 150,
    parameter int unsigned DET_DBC    = 20,
    parameter int unsigned TOG_PERIOD = 1000,
    parameter int unsigned TOG_SRC    = 400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] role_cfg,
    input  logic [1:0] cc1_lvl,
    input  logic [1:0] cc2_lvl,
    output logic       attached,
    output logic       orient,
    output logic       lane_flip,
    output logic       power_role,
    output logic [1:0] cur_class,
    output logic       vconn_cc1,
    output logic       vconn_cc2,
    output logic       pull_up
);
    role_cfg_e  cfg;
    att_state_e state_q;
    logic       role_q, orient_q, ra_q;
    logic [1:0] cls_q;
    obs_t       prev_q, obs_now;
    cand_t      cand;
    logic       tog_pu, tog_run, base_pu;
    logic       att_cond, att_done, det_cond, det_done;
    logic [1:0] own_code;

    assign cfg = role_cfg_e'(role_cfg);

    always_comb begin
        unique case (cfg)
            CFG_SINK: base_pu = 1'b0;
            CFG_SRC:  base_pu = 1'b1;
            default:  base_pu = tog_pu;
        endcase
    end

    assign pull_up  = (state_q == ST_ATT) ? role_q : base_pu;
    assign cand     = classify(pull_up, cc1_lvl, cc2_lvl);
    assign obs_now  = '{pu: pull_up, c1: cc1_lvl, c2: cc2_lvl};
    assign tog_run  = (state_q == ST_UNATT) && !cand.valid;
    assign att_cond = (state_q == ST_UNATT) && cand.valid && (obs_now == prev_q);
    assign own_code = orient_q ? cc2_lvl : cc1_lvl;
    assign det_cond = (state_q == ST_ATT) && !partner_seen(role_q, own_code);

    cc_drp_toggle #(.PERIOD(TOG_PERIOD), .SRC_CYC(TOG_SRC)) tog_i (
        .clk(clk), .rst(rst), .run(tog_run), .pu(tog_pu)
    );

    cc_hold_timer #(.LIMIT(ATT_DBC)) att_tmr_i (
        .clk(clk), .rst(rst), .cond(att_cond), .done(att_done)
    );

    cc_hold_timer #(.LIMIT(DET_DBC)) det_tmr_i (
        .clk(clk), .rst(rst), .cond(det_cond), .done(det_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_UNATT;
            prev_q   <= '0;
            role_q   <= 1'b0;
            orient_q <= 1'b0;
            cls_q    <= 2'd0;
            ra_q     <= 1'b0;
        end else begin
            prev_q <= obs_now;
            unique case (state_q)
                ST_UNATT: begin
                    if (att_done) begin
                        state_q  <= ST_ATT;
                        role_q   <= pull_up;
                        orient_q <= cand.pin;
                        cls_q    <= cand.cls;
                        ra_q     <= cand.ra_other;
                    end
                end
                ST_ATT: begin
                    if (det_done) begin
                        state_q <= ST_UNATT;
                        cls_q   <= 2'd0;
                        ra_q    <= 1'b0;
                    end else if (!role_q && own_code != LVL_OPEN) begin
                        cls_q <= own_code;
                    end
                end
                default: state_q <= ST_UNATT;
            endcase
        end
    end

    assign attached   = (state_q == ST_ATT);
    assign orient     = attached & orient_q;
    assign lane_flip  = orient;
    assign power_role = attached & role_q;
    assign cur_class  = cls_q;
    assign vconn_cc1  = attached & role_q & ra_q & orient_q;
    assign vconn_cc2  = attached & role_q & ra_q & ~orient_q;
endmodule

// File: rtl/cc_attach_det_chk.sv
module cc_attach_det_chk #(
    parameter int unsigned ATT_DBC = 150
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cc1_lvl,
    input logic [1:0] cc2_lvl,
    input logic       pull_up,
    input logic       attached,
    input logic       orient,
    input logic       power_role,
    input logic [1:0] cur_class,
    input logic       vconn_cc1,
    input logic       vconn_cc2
);
    localparam int unsigned SW = $clog2(ATT_DBC + 1) + 1;

    logic [4:0]    seen_q;
    logic [SW-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            stab_q <= '0;
        end else begin
            seen_q <= {pull_up, cc1_lvl, cc2_lvl};
            if ({pull_up, cc1_lvl, cc2_lvl} != seen_q)
                stab_q <= '0;
            else if (stab_q < SW'(ATT_DBC))
                stab_q <= stab_q + 1'b1;
        end
    end

    // R2
    attach_dbc_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(attached) |-> (stab_q >= SW'(ATT_DBC)));

    // R7
    role_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (attached && $past(attached)) |-> $stable(pull_up));

    // R4
    orient_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (attached && $past(attached)) |-> $stable(orient));

    // R9
    vconn_src_chk: assert property (@(posedge clk) disable iff (rst)
        (vconn_cc1 || vconn_cc2) |-> (attached && power_role));

    // R9
    vconn_side_chk: assert property (@(posedge clk) disable iff (rst)
        attached |-> !(orient ? vconn_cc2 : vconn_cc1));

    // R10
    vconn_off_chk: assert property (@(posedge clk) disable iff (rst)
        !attached |-> (!vconn_cc1 && !vconn_cc2));

    // R6
    class_sink_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_class != 2'd0) |-> (attached && !power_role));
endmodule

bind cc_attach_det cc_attach_det_chk #(.ATT_DBC(ATT_DBC)) chk_i (
    .clk(clk), .rst(rst), .cc1_lvl(cc1_lvl), .cc2_lvl(cc2_lvl),
    .pull_up(pull_up), .attached(attached), .orient(orient),
    .power_role(power_role), .cur_class(cur_class),
    .vconn_cc1(vconn_cc1), .vconn_cc2(vconn_cc2)
);

// File: tb/cc_attach_det_tb.sv
module cc_attach_det_tb_top;
    localparam int ATT = 8;
    localparam int DET = 4;
    localparam int PER = 40;
    localparam int SRC = 16;
    localparam int NV  = 12;

    // {cfg[1:0], cc1[1:0], cc2[1:0], att, ori, role, cls[1:0], v1, v2}
    localparam logic [12:0] TBL [NV] = '{
        13'b00_11_00_1_0_0_11_0_0,
        13'b00_00_01_1_1_0_01_0_0,
        13'b00_10_00_1_0_0_10_0_0,
        13'b00_10_10_0_0_0_00_0_0,
        13'b00_00_00_0_0_0_00_0_0,
        13'b01_10_00_1_0_1_00_0_0,
        13'b01_00_10_1_1_1_00_0_0,
        13'b01_10_01_1_0_1_00_0_1,
        13'b01_01_10_1_1_1_00_1_0,
        13'b01_10_10_0_0_0_00_0_0,
        13'b01_01_01_0_0_0_00_0_0,
        13'b01_11_00_0_0_0_00_0_0
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] role_cfg = 2'd0;
    logic [1:0] cc1_lvl = 2'd0;
    logic [1:0] cc2_lvl = 2'd0;
    logic       attached, orient, lane_flip, power_role, vconn_cc1, vconn_cc2, pull_up;
    logic [1:0] cur_class;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cc_attach_det #(.ATT_DBC(ATT), .DET_DBC(DET), .TOG_PERIOD(PER), .TOG_SRC(SRC)) dut_i (
        .clk(clk), .rst(rst), .role_cfg(role_cfg), .cc1_lvl(cc1_lvl), .cc2_lvl(cc2_lvl),
        .attached(attached), .orient(orient), .lane_flip(lane_flip),
        .power_role(power_role), .cur_class(cur_class),
        .vconn_cc1(vconn_cc1), .vconn_cc2(vconn_cc2), .pull_up(pull_up)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] cfg);
        @(negedge clk);
        rst = 1'b1; role_cfg = cfg; cc1_lvl = 2'd0; cc2_lvl = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int highs;
        // R1 reset state in dual-role mode
        do_reset(2'd2);
        chk("R1 attached", attached, 0);
        chk("R1 vconn", {vconn_cc1, vconn_cc2}, 0);
        chk("R1 class", cur_class, 0);
        chk("R1 pull_up", pull_up, 1);

        // table walk: R4 R5 R6 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            v = TBL[i];
            do_reset(v[12:11]);
            cc1_lvl = v[10:9];
            cc2_lvl = v[8:7];
            step(ATT + 4);
            chk($sformatf("R5/R6/R8 vec%0d attached", i), attached, v[6]);
            chk($sformatf("R4 vec%0d orient", i), orient, v[5]);
            chk($sformatf("R4 vec%0d lane_flip", i), lane_flip, v[5]);
            chk($sformatf("R5 vec%0d role", i), power_role, v[4]);
            chk($sformatf("R6 vec%0d class", i), cur_class, v[3:2]);
            chk($sformatf("R9 vec%0d vconn", i), {vconn_cc1, vconn_cc2}, v[1:0]);
        end

        // R2 exact attach timing and restart on a glitch
        do_reset(2'd0);
        cc1_lvl = 2'd2;
        step(ATT - 1);
        cc1_lvl = 2'd0;
        step(1);
        cc1_lvl = 2'd2;
        step(ATT);
        chk("R2 not yet after restart", attached, 0);
        step(1);
        chk("R2 attach edge", attached, 1);
        chk("R6 class 1.5A", cur_class, 2);

        // R6 class tracking while attached
        cc1_lvl = 2'd3;
        step(1);
        chk("R6 class follows", cur_class, 3);

        // R3 short loss ignored, full loss detaches
        cc1_lvl = 2'd0;
        step(DET - 1);
        cc1_lvl = 2'd3;
        step(2);
        chk("R3 short loss ignored", attached, 1);
        cc1_lvl = 2'd0;
        step(DET - 1);
        chk("R3 before detach", attached, 1);
        step(1);
        chk("R3 detached", attached, 0);
        chk("R6 class cleared", cur_class, 0);

        // R10 VCONN drops with detach
        do_reset(2'd1);
        cc1_lvl = 2'd2; cc2_lvl = 2'd1;
        step(ATT + 2);
        chk("R9 vconn on cc2", vconn_cc2, 1);
        cc1_lvl = 2'd0;
        step(DET - 1);
        chk("R10 vconn held pre-detach", vconn_cc2, 1);
        step(1);
        chk("R10 detach", attached, 0);
        chk("R10 vconn off", {vconn_cc1, vconn_cc2}, 0);

        // R7 toggle duty
        do_reset(2'd2);
        highs = 0;
        for (int k = 0; k < 2 * PER; k++) begin
            highs += int'(pull_up);
            step(1);
        end
        chk("R7 duty", highs, 2 * SRC);

        // R7 dual-role with a source partner on CC2
        for (int k = 0; k < 4 * PER && !attached; k++) begin
            cc1_lvl = 2'd0;
            cc2_lvl = pull_up ? 2'd0 : 2'd3;
            step(1);
        end
        chk("R7 drp attach as sink", attached, 1);
        chk("R7 role sink", power_role, 0);
        chk("R4 drp orient", orient, 1);
        chk("R6 drp class", cur_class, 3);
        highs = 0;
        for (int k = 0; k < 50; k++) begin
            highs += int'(pull_up);
            step(1);
        end
        chk("R7 toggle stopped", highs, 0);
        cc2_lvl = 2'd0;
        step(DET + 1);
        chk("R10 drp detach", attached, 0);
        highs = 0;
        for (int k = 0; k < PER; k++) begin
            highs += int'(pull_up);
            step(1);
        end
        chk("R10 toggling resumed", int'(highs > 0), 1);

        // R7 dual-role with a sink partner on CC1
        do_reset(2'd2);
        for (int k = 0; k < 4 * PER && !attached; k++) begin
            cc1_lvl = pull_up ? 2'd2 : 2'd0;
            cc2_lvl = 2'd0;
            step(1);
        end
        chk("R7 drp attach as source", attached, 1);
        chk("R7 role source", power_role, 1);
        chk("R4 drp orient cc1", orient, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule